// File: doc/BRIEF.md
# SPI Slave Receive Path with Per-Slot Chip-Select Hold

This block is the receive side of a multi-slot SPI slave. Serial words come in MSB first in SPI mode 0 and are gathered in a shift register. A small table of receive slots is filled in turn, and a write pointer steps through the slots. Each slot has its own hold-select bit, and that bit decides when the word just shifted in is written to the slot. When the bit is set, the word is written as soon as its last bit arrives. When the bit is clear, the word is parked until chip select goes inactive. Until then the slave stops responding: it drives a quiet output and ignores further clock edges.

A compatibility input sets aside the per-slot bits. In that mode every word is written as soon as it completes, and words may follow each other with chip select held low. The serial inputs are brought into the system clock domain through two-stage synchronisers before any edge is detected. Each write to a slot comes with a one-cycle commit strobe that carries the slot index and the data. The system side reads the filled slots in order through a valid/ready port.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, `spi_somi`, `rx_commit` and `rd_valid` are 0, and the first word committed goes to slot 0.
- R2: Data on `spi_simo` is taken on each rising edge of `spi_sclk` while `spi_cs_n` is low, most significant bit first. A word is WIDTH bits (default 16).
- R3: When the current slot's hold-select bit is 1 (and compatibility is off), the word is committed once its last bit has been taken, even though `spi_cs_n` is still low.
- R4: When the current slot's hold-select bit is 0 (and compatibility is off), the finished word is not committed while `spi_cs_n` stays low. It is committed once `spi_cs_n` goes high.
- R5: While a word waits for chip-select release, `spi_sclk` edges do not start a new word and `spi_somi` stays 0. After `spi_cs_n` has gone high and low again, words are accepted as usual.
- R6: With hold-select bits of 1, several words in a row are each committed under one continuous low period of `spi_cs_n`.
- R7: With `compat_en` = 1, hold-select bits are ignored. Every word is committed on completion, and words follow each other with `spi_cs_n` held low.
- R8: The write slot index advances by one after each commit and wraps from slot NSLOT-1 (default 7) to slot 0.
- R9: `rx_commit` is high for exactly one system clock per committed word. At that cycle `rx_commit_idx` and `rx_commit_data` give the slot and the word written.
- R10: `rd_valid` is 1 when the slot at `rd_idx` holds an unread word, and `rd_data` is that word. A cycle with `rd_valid` and `rd_ready` both high consumes the word and moves `rd_idx` to the next slot, wrapping.
- R11: If `spi_cs_n` goes high before a word is complete, the partial bits are discarded and nothing is committed.
- R12: `spi_somi` carries `tx_word` MSB first. Its first bit is present from the falling edge of `spi_cs_n`, before the first rising clock edge, and it moves to the next bit on each falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| compat_en | input | 1 | 1 = ignore hold-select bits and commit every word on completion |
| slot_hold | input | NSLOT | Hold-select bit per slot; bit n belongs to slot n |
| tx_word | input | WIDTH | Word sent out on `spi_somi` during each transfer |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock (mode 0), asynchronous |
| spi_simo | input | 1 | Serial data in |
| spi_somi | output | 1 | Serial data out; 0 when idle or blocked |
| rx_commit | output | 1 | One-cycle strobe for each slot write |
| rx_commit_idx | output | $clog2(NSLOT) | Slot written with the strobe |
| rx_commit_data | output | WIDTH | Word written with the strobe |
| rd_valid | output | 1 | Slot at `rd_idx` holds an unread word |
| rd_ready | input | 1 | System accepts the word at `rd_idx` |
| rd_idx | output | $clog2(NSLOT) | Slot offered to the system |
| rd_data | output | WIDTH | Word in the slot at `rd_idx` |

## Verification
A pin change reaches the edge detector after three system clocks: two synchroniser stages and one previous-value register. The commit strobe therefore rises three clocks after the last rising `spi_sclk`, or three clocks after `spi_cs_n` rises when the word was held. `rd_valid` follows one clock after the strobe. The bench keeps each serial half-period at four clocks and waits at least six clocks after a word or a chip-select change before it compares anything. A monitor samples the strobe on every falling clock edge and records its count, index, data and pulse width, so no comparison depends on catching the exact edge. The bench checks the "no commit" cases by showing that the strobe count stays unchanged across a wait of ten or more clocks.

// File: rtl/shs_pkg.sv
package shs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } slv_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic simo;
    } spi_pins_t;

    typedef struct packed {
        logic cs_low;
        logic cs_fall;
        logic cs_rise;
        logic sclk_rise;
        logic sclk_fall;
        logic simo;
    } spi_evt_t;

    localparam spi_pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, simo: 1'b0};

    function automatic spi_evt_t detect_events(spi_pins_t cur, spi_pins_t prev);
        spi_evt_t e;
        e.cs_low    = ~cur.cs_n;
        e.cs_fall   = ~cur.cs_n & prev.cs_n;
        e.cs_rise   = cur.cs_n & ~prev.cs_n;
        e.sclk_rise = cur.sclk & ~prev.sclk;
        e.sclk_fall = ~cur.sclk & prev.sclk;
        e.simo      = cur.simo;
        return e;
    endfunction

    function automatic int unsigned next_slot(int unsigned cur, int unsigned nslot);
        return (cur + 1 >= nslot) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/shs_pin_sync.sv
module shs_pin_sync
    import shs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n_in,
    input  logic     sclk_in,
    input  logic     simo_in,
    output logic     cs_low,
    output logic     cs_fall,
    output logic     cs_rise,
    output logic     sclk_rise,
    output logic     sclk_fall,
    output logic     simo_bit
);
    spi_pins_t pins_in;
    spi_pins_t chain [STAGES];
    spi_pins_t prev;
    spi_evt_t  evt;

    assign pins_in = '{cs_n: cs_n_in, sclk: sclk_in, simo: simo_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= PINS_IDLE;
            prev <= PINS_IDLE;
        end else begin
            chain[0] <= pins_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
        end
    end

    assign evt       = detect_events(chain[STAGES-1], prev);
    assign cs_low    = evt.cs_low;
    assign cs_fall   = evt.cs_fall;
    assign cs_rise   = evt.cs_rise;
    assign sclk_rise = evt.sclk_rise;
    assign sclk_fall = evt.sclk_fall;
    assign simo_bit  = evt.simo;

endmodule

// File: rtl/shs_shifter.sv
module shs_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             restart,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             simo_bit,
    input  logic [WIDTH-1:0] tx_word,
    output logic             word_done,
    output logic [WIDTH-1:0] word_val,
    output logic             tx_msb
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [WIDTH-1:0] rx_sr;
    logic [WIDTH-1:0] tx_sr;

    assign word_done = active & sclk_rise & (bit_cnt == LAST_BIT);
    assign word_val  = {rx_sr[WIDTH-2:0], simo_bit};
    assign tx_msb    = tx_sr[WIDTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else if (restart) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= tx_word;
        end else if (active && sclk_rise) begin
            rx_sr <= word_val;
            if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                tx_sr   <= tx_word;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end else if (active && sclk_fall && bit_cnt != '0) begin
            tx_sr <= {tx_sr[WIDTH-2:0], 1'b0};
        end
    end

    // R2: a word boundary resets the bit counter
    a_r2_count_wraps: assert property (@(posedge clk) disable iff (rst)
        word_done |=> (bit_cnt == '0));

endmodule

// File: rtl/shs_commit_ctrl.sv
module shs_commit_ctrl
    import shs_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NSLOT = 8,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             compat_en,
    input  logic [NSLOT-1:0] slot_hold,
    input  logic             cs_low,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             word_done,
    input  logic [WIDTH-1:0] word_val,
    output logic             shifting,
    output logic             rx_commit,
    output logic [IDX_W-1:0] rx_idx,
    output logic [WIDTH-1:0] rx_data
);
    slv_state_e       state;
    logic [IDX_W-1:0] wr_ptr;
    logic [WIDTH-1:0] parked;
    logic             commit_now;

    assign commit_now = compat_en | slot_hold[wr_ptr];
    assign shifting   = (state == ST_SHIFT) & cs_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            wr_ptr    <= '0;
            parked    <= '0;
            rx_commit <= 1'b0;
            rx_idx    <= '0;
            rx_data   <= '0;
        end else begin
            rx_commit <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        state <= ST_IDLE;
                    end else if (word_done) begin
                        if (commit_now) begin
                            rx_commit <= 1'b1;
                            rx_idx    <= wr_ptr;
                            rx_data   <= word_val;
                            wr_ptr    <= IDX_W'(next_slot(int'(wr_ptr), NSLOT));
                        end else begin
                            parked <= word_val;
                            state  <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (cs_rise) begin
                        rx_commit <= 1'b1;
                        rx_idx    <= wr_ptr;
                        rx_data   <= parked;
                        wr_ptr    <= IDX_W'(next_slot(int'(wr_ptr), NSLOT));
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: strobe lasts a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_commit |=> !rx_commit);

    // R8: write pointer already points past the slot just written
    a_r8_ptr_advance: assert property (@(posedge clk) disable iff (rst)
        rx_commit |-> (wr_ptr == IDX_W'(next_slot(int'(rx_idx), NSLOT))));

    // R4: no commit while a parked word still sees chip select low
    a_r4_hold_waits: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && cs_low) |=> !rx_commit);

    // R5: clock edges do not leave the parked state
    a_r5_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !cs_rise) |=> (state == ST_HOLD));

    // R3, R7: finished word with commit enabled is strobed next cycle
    a_r3_commit_on_done: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && !cs_rise && word_done && commit_now) |=> rx_commit);

endmodule

// File: rtl/shs_rx_buffer.sv
module shs_rx_buffer
    import shs_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NSLOT = 8,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_mem [NSLOT];
    logic [NSLOT-1:0] slot_full;
    logic [IDX_W-1:0] rd_ptr;
    logic             pop;

    assign rd_idx   = rd_ptr;
    assign rd_valid = slot_full[rd_ptr];
    assign rd_data  = slot_mem[rd_ptr];
    assign pop      = rd_valid & rd_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_full <= '0;
            rd_ptr    <= '0;
        end else begin
            if (pop) begin
                slot_full[rd_ptr] <= 1'b0;
                rd_ptr <= IDX_W'(next_slot(int'(rd_ptr), NSLOT));
            end
            if (wr_en) slot_full[wr_idx] <= 1'b1;
        end
    end

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) slot_mem[s] <= '0;
                else if (wr_en && wr_idx == IDX_W'(s)) slot_mem[s] <= wr_data;
            end
        end
    endgenerate

    // R10: a consumed word advances the read index by one slot
    a_r10_pop_step: assert property (@(posedge clk) disable iff (rst)
        pop |=> (rd_ptr == IDX_W'(next_slot(int'($past(rd_ptr)), NSLOT))));

    // R10: a written slot reads back as occupied
    a_r10_fill: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot_full[$past(wr_idx)]);

endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
    import shs_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int NSLOT     = 8,
    parameter int SYNC_STGS = 2,
    localparam int IDX_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             compat_en,
    input  logic [NSLOT-1:0] slot_hold,
    input  logic [WIDTH-1:0] tx_word,
    input  logic             spi_cs_n,
    input  logic             spi_sclk,
    input  logic             spi_simo,
    output logic             spi_somi,
    output logic             rx_commit,
    output logic [IDX_W-1:0] rx_commit_idx,
    output logic [WIDTH-1:0] rx_commit_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic             cs_low, cs_fall, cs_rise;
    logic             sclk_rise, sclk_fall, simo_bit;
    logic             shifting, word_done, tx_msb;
    logic [WIDTH-1:0] word_val;

    shs_pin_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .cs_n_in   (spi_cs_n),
        .sclk_in   (spi_sclk),
        .simo_in   (spi_simo),
        .cs_low    (cs_low),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .simo_bit  (simo_bit)
    );

    shs_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (shifting),
        .restart   (cs_fall | cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .simo_bit  (simo_bit),
        .tx_word   (tx_word),
        .word_done (word_done),
        .word_val  (word_val),
        .tx_msb    (tx_msb)
    );

    shs_commit_ctrl #(.WIDTH(WIDTH), .NSLOT(NSLOT)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .compat_en (compat_en),
        .slot_hold (slot_hold),
        .cs_low    (cs_low),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .word_done (word_done),
        .word_val  (word_val),
        .shifting  (shifting),
        .rx_commit (rx_commit),
        .rx_idx    (rx_commit_idx),
        .rx_data   (rx_commit_data)
    );

    shs_rx_buffer #(.WIDTH(WIDTH), .NSLOT(NSLOT)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (rx_commit),
        .wr_idx   (rx_commit_idx),
        .wr_data  (rx_commit_data),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    assign spi_somi = shifting & tx_msb;

    // R1: nothing is presented during reset's aftermath with chip select high
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !cs_low |-> !spi_somi);

endmodule

// File: tb/sim_spi_hold_slave.sv
module sim_spi_hold_slave;
    localparam int W     = 16;
    localparam int NS    = 8;
    localparam int HALF  = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          compat_en;
    logic [NS-1:0] slot_hold;
    logic [W-1:0]  tx_word;
    logic          spi_cs_n, spi_sclk, spi_simo, spi_somi;
    logic          rx_commit;
    logic [2:0]    rx_commit_idx;
    logic [W-1:0]  rx_commit_data;
    logic          rd_valid, rd_ready;
    logic [2:0]    rd_idx;
    logic [W-1:0]  rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int n_commit = 0;
    int exp_ptr  = 0;
    logic [2:0]   last_idx;
    logic [W-1:0] last_data;
    logic         prev_commit = 1'b0;
    logic         long_pulse  = 1'b0;
    logic [W-1:0] somi_seen;

    always #4 clk = ~clk;

    spi_hold_slave u0 (
        .clk(clk), .rst(rst), .compat_en(compat_en), .slot_hold(slot_hold),
        .tx_word(tx_word), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_simo(spi_simo), .spi_somi(spi_somi), .rx_commit(rx_commit),
        .rx_commit_idx(rx_commit_idx), .rx_commit_data(rx_commit_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always @(negedge clk) begin
        if (rx_commit) begin
            n_commit  <= n_commit + 1;
            last_idx  <= rx_commit_idx;
            last_data <= rx_commit_data;
            if (prev_commit) long_pulse <= 1'b1;
        end
        prev_commit <= rx_commit;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_drop();
        spi_cs_n = 1'b0;
        wait_clk(8);
    endtask

    task automatic cs_release();
        spi_cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_bits(input logic [W-1:0] data, input int nbits);
        somi_seen = '0;
        for (int i = 0; i < nbits; i++) begin
            spi_simo = data[W-1-i];
            wait_clk(HALF);
            somi_seen = {somi_seen[W-2:0], spi_somi};
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
    endtask

    task automatic expect_commit(input string req, input int base, input logic [W-1:0] data);
        chk(req, n_commit, base + 1);
        chk(req, {29'd0, last_idx}, exp_ptr);
        chk(req, {16'd0, last_data}, {16'd0, data});
        exp_ptr = (exp_ptr + 1) % NS;
    endtask

    task automatic t_reset();
        chk("R1 somi", {31'd0, spi_somi}, 0);
        chk("R1 commit", {31'd0, rx_commit}, 0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 0);
        chk("R1 count", n_commit, 0);
    endtask

    task automatic t_read();
        int base;
        slot_hold = '1;
        base = n_commit;
        cs_drop();
        send_bits(16'h1234, W); wait_clk(6);
        expect_commit("R1 first slot", base, 16'h1234);
        send_bits(16'hBEEF, W); wait_clk(6);
        expect_commit("R10 second", base + 1, 16'hBEEF);
        cs_release();
        chk("R10 valid", {31'd0, rd_valid}, 1);
        chk("R10 idx0", {29'd0, rd_idx}, 0);
        chk("R10 data0", {16'd0, rd_data}, 32'h1234);
        rd_ready = 1'b1; wait_clk(1); rd_ready = 1'b0;
        chk("R10 idx1", {29'd0, rd_idx}, 1);
        chk("R10 data1", {16'd0, rd_data}, 32'hBEEF);
        rd_ready = 1'b1; wait_clk(1); rd_ready = 1'b0;
        chk("R10 empty", {31'd0, rd_valid}, 0);
        chk("R10 idx2", {29'd0, rd_idx}, 2);
    endtask

    task automatic t_hold_set();
        int base;
        base = n_commit;
        cs_drop();
        send_bits(16'hA5C3, W); wait_clk(6);
        chk("R3 cs still low", {31'd0, spi_cs_n}, 0);
        expect_commit("R3 R2 immediate commit", base, 16'hA5C3);
        chk("R12 somi word", {16'd0, somi_seen}, {16'd0, tx_word});
        cs_release();
    endtask

    task automatic t_back_to_back();
        int base;
        base = n_commit;
        cs_drop();
        send_bits(16'h0001, W); wait_clk(6);
        expect_commit("R6 word1", base, 16'h0001);
        send_bits(16'h8000, W); wait_clk(6);
        expect_commit("R6 word2", base + 1, 16'h8000);
        chk("R12 reload", {16'd0, somi_seen}, {16'd0, tx_word});
        send_bits(16'hFFFF, W); wait_clk(6);
        expect_commit("R6 word3", base + 2, 16'hFFFF);
        cs_release();
    endtask

    task automatic t_hold_clear();
        int base;
        slot_hold = '0;
        base = n_commit;
        cs_drop();
        send_bits(16'h5A5A, W); wait_clk(10);
        chk("R4 no early commit", n_commit, base);
        send_bits(16'h0F0F, W); wait_clk(10);
        chk("R5 edges ignored", n_commit, base);
        chk("R5 somi quiet", {16'd0, somi_seen}, 0);
        cs_release();
        expect_commit("R4 commit on release", base, 16'h5A5A);
        cs_drop();
        send_bits(16'h1111, W); wait_clk(6);
        chk("R5 restart held", n_commit, base + 1);
        cs_release();
        expect_commit("R8 last slot", base + 1, 16'h1111);
    endtask

    task automatic t_compat();
        int base;
        compat_en = 1'b1;
        slot_hold = '0;
        base = n_commit;
        cs_drop();
        send_bits(16'h2222, W); wait_clk(6);
        expect_commit("R7 R8 wrap to slot0", base, 16'h2222);
        send_bits(16'h3333, W); wait_clk(6);
        expect_commit("R7 back to back", base + 1, 16'h3333);
        cs_release();
        compat_en = 1'b0;
    endtask

    task automatic t_abort();
        int base;
        slot_hold = '1;
        base = n_commit;
        cs_drop();
        send_bits(16'hFFFF, 7);
        cs_release();
        wait_clk(6);
        chk("R11 partial dropped", n_commit, base);
        cs_drop();
        send_bits(16'h7E81, W); wait_clk(6);
        expect_commit("R11 clean restart", base, 16'h7E81);
        cs_release();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; compat_en = 1'b0; slot_hold = '1; tx_word = 16'h3C96;
        spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_simo = 1'b0; rd_ready = 1'b0;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_read();
        t_hold_set();
        t_back_to_back();
        t_hold_clear();
        t_compat();
        t_abort();
        chk("R9 pulse width", {31'd0, long_pulse}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule